// File: doc/BRIEF.md
# Fourfold-Oversampling Asynchronous Character Receiver

This block takes an asynchronous serial line and turns it into bytes. Each character on the line has a low start bit, eight data bits sent least significant bit first, an even-parity bit and a high stop bit. The block does not divide a clock for the baud rate. The surrounding logic supplies a one-cycle enable, `tick_4x_i`, that pulses four times per bit period. All receiver timing counts these enables.

The line first passes through a synchroniser. The receiver then waits for the line to go low, which is the falling edge of a start bit. Two ticks later, at the middle of the start bit, it reads the line again. If the line has returned high, the receiver drops the character and goes back to looking for an edge. After the start bit, the receiver reads the data bits, the parity bit and the stop bit once each, four ticks apart, at the middle of each bit.

When it reads the stop bit, the receiver presents the byte and a one-cycle valid strobe. It also presents a parity flag and a framing flag. These three outputs hold their values until the next character completes. Two static inputs relax the checks for lines with heavy distortion. One turns off the mid-point check of the start bit. The other turns off the stop-bit check.

Top module: `ovs4_uart_rx`

## Requirements
- R1: While reset is asserted, `valid_o`, `data_o`, `parity_err_o` and `frame_err_o` are all zero.
- R2: Each character that is received produces exactly one `valid_o` pulse, one clock cycle wide. The pulse appears in the cycle after the tick on which the stop bit is sampled.
- R3: `data_o` holds the eight data bits in the order they arrived. The first bit after the start bit goes to `data_o[0]`. The parity bit follows the eighth data bit, and the stop bit follows the parity bit.
- R4: `parity_err_o` is 1 when the eight data bits and the parity bit together contain an odd number of ones. Otherwise it is 0.
- R5: When `stop_chk_off_i` is 0, `frame_err_o` is 1 exactly when the stop bit is read as low.
- R6: When `stop_chk_off_i` is 1, a low stop bit still delivers its character, and `frame_err_o` stays 0.
- R7: When `start_chk_off_i` is 0, the start bit is read again two ticks after the falling edge. If the line is high at that point, the character is dropped and no `valid_o` is produced. This holds for a low pulse that lasts one tick or two ticks.
- R8: When `start_chk_off_i` is 1, the receiver skips the mid-point check. A one-tick low glitch on an otherwise idle line then yields a full character: data 0xFF, `parity_err_o`=1, `frame_err_o`=0.
- R9: If the stop bit is read as low, the receiver does not look for a new edge until it has read the line as high on some tick. A line that stays low after a low stop bit therefore yields no extra character.
- R10: While `valid_o` is low, `data_o`, `parity_err_o` and `frame_err_o` do not change.
- R11: When the stop bit is high, the receiver is ready for the next falling edge on the following tick. A start bit that begins right after the stop bit period ends is therefore received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_4x_i | input | 1 | Sample enable, four pulses per bit period |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| start_chk_off_i | input | 1 | 1 = skip the mid-point check of the start bit |
| stop_chk_off_i | input | 1 | 1 = never report a low stop bit |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe when a character completes |
| parity_err_o | output | 1 | Even-parity failure of the last character |
| frame_err_o | output | 1 | Low stop bit in the last character (check enabled) |

## Verification
The bench targets four kinds of corner case:
- **Short start pulses.** It sends low glitches of one and two ticks with the start check on. A receiver that skipped the mid-point recheck would emit a spurious character here.
- **The same glitch with the start check off.** A receiver that ignored the configuration would emit nothing instead of an all-ones character.
- **A low stop bit followed by a line held low.** A receiver that re-armed at once would report a phantom character.
- **Back-to-back characters with no idle time.** A receiver that took an extra tick to re-arm would lose the edge or read every later bit one tick late.

Random characters with wrong parity, low stop bits and mixed configuration settings then check how the flags are formed.

// File: rtl/ovs4_rx_pkg.sv
`timescale 1ns/1ps
package ovs4_rx_pkg;

  // Receiver sequencing states
  typedef enum logic [1:0] {
    ST_WAIT_HIGH = 2'd0,  // line must be seen high before arming
    ST_HUNT      = 2'd1,  // armed, looking for a low sample
    ST_START     = 2'd2,  // counting to the middle of the start bit
    ST_SHIFT     = 2'd3   // sampling data, parity and stop bits
  } rx_state_e;

endpackage

// File: rtl/ovs4_sync.sv
`timescale 1ns/1ps
// Multi-stage flop chain with asynchronous clear to RST_VAL.
// Used both for the serial line and for the reset release.
module ovs4_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ovs4_rx_ctrl.sv
`timescale 1ns/1ps
// Bit timing and sequencing. Advances only on sample ticks.
module ovs4_rx_ctrl
  import ovs4_rx_pkg::*;
#(
  parameter int OVS       = 4,
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_i,
  input  logic start_chk_off_i,
  output logic samp_o,   // data or parity bit sample
  output logic done_o    // stop bit sample
);

  localparam int PW       = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int LAST_IDX = DATA_BITS + 1;           // stop bit index
  localparam int IW       = $clog2(LAST_IDX + 1);
  localparam logic [PW-1:0] HALF_M1 = PW'(OVS/2 - 1);
  localparam logic [PW-1:0] FULL_M1 = PW'(OVS - 1);
  localparam logic [IW-1:0] LAST_I  = IW'(LAST_IDX);

  rx_state_e     state_q, state_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    samp_o  = 1'b0;
    done_o  = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        ST_WAIT_HIGH: begin
          if (line_i) state_d = ST_HUNT;
        end
        ST_HUNT: begin
          if (!line_i) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == HALF_M1) begin
            cnt_d = '0;
            idx_d = '0;
            if (!line_i || start_chk_off_i) state_d = ST_SHIFT;
            else                            state_d = ST_HUNT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (cnt_q == FULL_M1) begin
            cnt_d = '0;
            if (idx_q == LAST_I) begin
              done_o  = 1'b1;
              state_d = line_i ? ST_HUNT : ST_WAIT_HIGH;
            end else begin
              samp_o = 1'b1;
              idx_d  = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_WAIT_HIGH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_HIGH;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (tick_i) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/ovs4_rx_frame.sv
`timescale 1ns/1ps
// Shift register, parity and stop evaluation, output holding registers.
module ovs4_rx_frame #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 samp_i,
  input  logic                 done_i,
  input  logic                 line_i,
  input  logic                 stop_chk_off_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 parity_err_o,
  output logic                 frame_err_o
);

  // data bits in [DATA_BITS-1:0], parity in [DATA_BITS]
  logic [DATA_BITS:0]   sh_q, sh_d;
  logic [DATA_BITS-1:0] data_d;
  logic                 perr_d, ferr_d, valid_d;

  always_comb begin
    sh_d    = sh_q;
    data_d  = data_o;
    perr_d  = parity_err_o;
    ferr_d  = frame_err_o;
    valid_d = done_i;
    if (samp_i) sh_d = {line_i, sh_q[DATA_BITS:1]};
    if (done_i) begin
      data_d = sh_q[DATA_BITS-1:0];
      perr_d = ^sh_q;
      ferr_d = ~line_i & ~stop_chk_off_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (samp_i) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o       <= '0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else if (done_i) begin
      data_o       <= data_d;
      parity_err_o <= perr_d;
      frame_err_o  <= ferr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_d;
  end

endmodule

// File: rtl/ovs4_uart_rx.sv
`timescale 1ns/1ps
module ovs4_uart_rx #(
  parameter int OVS         = 4,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_4x_i,
  input  logic                 rxd_i,
  input  logic                 start_chk_off_i,
  input  logic                 stop_chk_off_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 parity_err_o,
  output logic                 frame_err_o
);

  logic rst_sn;
  logic line_s;
  logic samp;
  logic done;

  // reset: asserted asynchronously, released on the clock
  ovs4_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sn)
  );

  ovs4_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  ovs4_rx_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_sn),
    .tick_i          (tick_4x_i),
    .line_i          (line_s),
    .start_chk_off_i (start_chk_off_i),
    .samp_o          (samp),
    .done_o          (done)
  );

  ovs4_rx_frame #(.DATA_BITS(DATA_BITS)) u_frame (
    .clk            (clk),
    .rst_n          (rst_sn),
    .samp_i         (samp),
    .done_i         (done),
    .line_i         (line_s),
    .stop_chk_off_i (stop_chk_off_i),
    .data_o         (data_o),
    .valid_o        (valid_o),
    .parity_err_o   (parity_err_o),
    .frame_err_o    (frame_err_o)
  );

endmodule

// File: rtl/ovs4_uart_rx_chk.sv
`timescale 1ns/1ps
module ovs4_uart_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_i,
  input logic                 line_i,
  input logic                 stop_chk_off_i,
  input logic [DATA_BITS-1:0] data_o,
  input logic                 valid_o,
  input logic                 parity_err_o,
  input logic                 frame_err_o
);

  // R2
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R2
  valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(tick_i));

  // R10
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(data_o) && $stable(parity_err_o) && $stable(frame_err_o)));

  // R6
  stop_off_no_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(stop_chk_off_i)) |-> !frame_err_o);

  // R5
  stop_low_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !$past(stop_chk_off_i)) |-> (frame_err_o == !$past(line_i)));

endmodule

bind ovs4_uart_rx ovs4_uart_rx_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk            (clk),
  .rst_n          (rst_sn),
  .tick_i         (tick_4x_i),
  .line_i         (line_s),
  .stop_chk_off_i (stop_chk_off_i),
  .data_o         (data_o),
  .valid_o        (valid_o),
  .parity_err_o   (parity_err_o),
  .frame_err_o    (frame_err_o)
);

// File: tb/ovs4_uart_rx_tb_top.sv
`timescale 1ns/1ps
module ovs4_uart_rx_tb_top;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       rxd;
  logic       start_off;
  logic       stop_off;
  logic [7:0] data_o;
  logic       valid_o;
  logic       perr_o;
  logic       ferr_o;

  int errors = 0;
  int checks = 0;
  int vcnt   = 0;
  logic [7:0] cap_data;
  logic       cap_perr;
  logic       cap_ferr;
  logic       done = 1'b0;

  ovs4_uart_rx dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_4x_i       (tick),
    .rxd_i           (rxd),
    .start_chk_off_i (start_off),
    .stop_chk_off_i  (stop_off),
    .data_o          (data_o),
    .valid_o         (valid_o),
    .parity_err_o    (perr_o),
    .frame_err_o     (ferr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // one tick every four clocks, changed away from the active edge
  initial begin
    tick = 1'b0;
    forever begin
      for (int ph = 0; ph < 4; ph++) begin
        @(negedge clk);
        tick = (ph == 0);
      end
    end
  end

  // capture each strobe
  always @(negedge clk) begin
    if (valid_o) begin
      vcnt     = vcnt + 1;
      cap_data = data_o;
      cap_perr = perr_o;
      cap_ferr = ferr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic exp_perr(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic exp_ferr(input logic stp, input logic off);
    return !stp && !off;
  endfunction

  // drive v for n sample ticks
  task automatic hold(input logic v, input int n);
    rxd = v;
    for (int i = 0; i < n; i++) @(posedge clk iff tick);
    @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic p, input logic stp, input int gap);
    hold(1'b0, 4);
    for (int i = 0; i < 8; i++) hold(d[i], 4);
    hold(p, 4);
    hold(stp, 4);
    if (gap > 0) hold(1'b1, gap);
  endtask

  task automatic expect_char(input int base, input logic [7:0] d, input logic pe, input logic fe);
    chk(vcnt == base + 1, "R2", vcnt, base + 1);
    chk(cap_data == d, "R3", cap_data, d);
    chk(cap_perr == pe, "R4", cap_perr, pe);
    if (stop_off) chk(cap_ferr == fe, "R6", cap_ferr, fe);
    else          chk(cap_ferr == fe, "R5", cap_ferr, fe);
    // R10: outputs still hold the last character
    chk(data_o == d && perr_o == pe && ferr_o == fe, "R10", {perr_o, ferr_o, data_o},
        {pe, fe, d});
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] d;
    logic p, stp;
    void'($urandom(32'h1234_5A5A));
    rxd = 1'b1; start_off = 1'b0; stop_off = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid_o == 0 && data_o == 0 && perr_o == 0 && ferr_o == 0, "R1",
        {valid_o, perr_o, ferr_o, data_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    hold(1'b1, 4);

    // directed: good character, correct parity
    base = vcnt; send_char(8'hA5, 1'b0, 1'b1, 4);
    expect_char(base, 8'hA5, 1'b0, 1'b0);

    // R4 wrong parity
    base = vcnt; send_char(8'h01, 1'b0, 1'b1, 4);
    expect_char(base, 8'h01, 1'b1, 1'b0);

    // R5 low stop, check enabled
    base = vcnt; send_char(8'h3C, 1'b0, 1'b0, 4);
    expect_char(base, 8'h3C, 1'b0, 1'b1);

    // R6 low stop, check disabled
    stop_off = 1'b1;
    base = vcnt; send_char(8'hC3, 1'b0, 1'b0, 4);
    expect_char(base, 8'hC3, 1'b0, 1'b0);
    stop_off = 1'b0;

    // R7 one-tick and two-tick glitches are dropped
    base = vcnt; hold(1'b0, 1); hold(1'b1, 48);
    chk(vcnt == base, "R7", vcnt, base);
    base = vcnt; hold(1'b0, 2); hold(1'b1, 48);
    chk(vcnt == base, "R7", vcnt, base);

    // R8 glitch accepted with the start check off
    start_off = 1'b1;
    base = vcnt; hold(1'b0, 1); hold(1'b1, 48);
    expect_char(base, 8'hFF, 1'b1, 1'b0);
    chk(vcnt == base + 1, "R8", vcnt, base + 1);
    start_off = 1'b0;

    // R9 low stop then line held low: no phantom character
    base = vcnt; send_char(8'h5A, 1'b0, 1'b0, 0);
    hold(1'b0, 40);
    chk(vcnt == base + 1, "R9", vcnt, base + 1);
    hold(1'b1, 4);
    base = vcnt; send_char(8'h81, 1'b0, 1'b1, 4);
    expect_char(base, 8'h81, 1'b0, 1'b0);

    // R11 back-to-back characters, no idle between them
    base = vcnt; send_char(8'h6E, 1'b1, 1'b1, 0);
    send_char(8'h17, 1'b0, 1'b1, 4);
    chk(vcnt == base + 2, "R11", vcnt, base + 2);
    chk(cap_data == 8'h17 && cap_perr == 1'b0, "R11", {cap_perr, cap_data}, 8'h17);

    // random characters and configurations
    for (int k = 0; k < 40; k++) begin
      d         = 8'($urandom);
      p         = ($urandom % 4 == 0) ? ~(^d) : (^d);
      stp       = ($urandom % 4 != 0);
      stop_off  = 1'($urandom);
      start_off = 1'($urandom);
      base = vcnt;
      send_char(d, p, stp, stp ? int'($urandom % 6) + 1 : int'($urandom % 6) + 2);
      expect_char(base, d, exp_perr(d, p), exp_ferr(stp, stop_off));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule